// File: doc/BRIEF.md
# Tape Interrecord Gap Timing Controller

This block walks a single tape operation through its motion phases: waiting, the start-up gap delay, data reading, and the slow-down gap delay after the record. It asserts the tape-motion enable for the whole operation. It requests a delay code from the transport at the start of each gap, with a select that tells the transport which kind of code it wants. It then times that gap in units of the transport's character clock.

Each gap delay uses an 8-bit counter that starts at the ones' complement of a shaped code and is clocked through a 5-bit prescaler. The prescaler is preset to all ones. The first character tick therefore steps the counter at once, and each later step takes 32 ticks. A code of c thus ends the gap on tick 1 + 32·c after counting starts. For the start-up gap, the code from the transport is widened by ORing in fixed bits. These bits depend on the operation: a read, a file-mark or long-gap write, or a start at beginning of tape. When several of these cases apply, their bits merge rather than add. A rewind opens motion for a single cycle and runs no gap delay.

Top module: `tape_gap_sequencer`

## Requirements
- R1: The phase output {accel, decel, delay} takes only the values waiting=100, start-up gap=101, reading=000 and slow-down gap=011. After reset it reads 100, and motion_en, read_en, code_req and delay_active are all low.
- R2: When op_start arrives in the waiting phase without cmd_rewind, the next cycle shows phase 101 and motion_en high. code_req is then high for exactly REQ_CYCLES cycles, with code_sel_decel low and delay_active high.
- R3: Once code_req falls, the gap ends on character tick number 1 + 32·c, where c is the shaped code. The tick before that leaves the gap still running. Ticks that arrive while code_req is high have no effect on the count.
- R4: For a start-up gap with cmd_write low, c = delay_code OR 0x01. A read code of 0 therefore lasts 33 ticks.
- R5: For a start-up gap with cmd_write high and either cmd_filemark or cmd_extgap high, c = delay_code OR 0x60. A plain write uses delay_code unchanged.
- R6: For a start-up gap with at_bot high, c is further ORed with 0xC0 for a write and with 0x60 for a read. All added bits combine by OR.
- R7: When the start-up gap ends, the phase becomes 000 and read_en rises in the same cycle that delay_active falls.
- R8: eor_strobe in the reading phase starts the slow-down gap. The phase becomes 011, code_req pulses with code_sel_decel high, and the slow-down code is used without change.
- R9: When the slow-down gap ends, the phase returns to 100 and motion_en and read_en go low.
- R10: op_start with cmd_rewind in the waiting phase raises motion_en for exactly one cycle. The phase stays 100 and no code request is made.
- R11: op_start outside the waiting phase, and eor_strobe outside the reading phase, leave the phase and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle operation start pulse |
| cmd_rewind | input | 1 | Operation is a rewind |
| cmd_write | input | 1 | Operation writes |
| cmd_filemark | input | 1 | Write is a file mark |
| cmd_extgap | input | 1 | Write with extended gap |
| at_bot | input | 1 | Tape is at beginning of tape when started |
| delay_code | input | 8 | Gap code supplied by the transport while code_req is high |
| char_tick | input | 1 | One-cycle pulse per character clock |
| eor_strobe | input | 1 | End-of-record strobe |
| motion_en | output | 1 | Tape motion enable |
| read_en | output | 1 | Reading phase active |
| code_req | output | 1 | Code request pulse |
| code_sel_decel | output | 1 | Low requests the start-up code, high the slow-down code |
| delay_active | output | 1 | Gap delay in progress |
| phase | output | 3 | {accel, decel, delay} phase bits |

## Verification
The hardest cases to reach are the long start-up gaps whose code combines several added bit groups, for example a file-mark write at beginning of tape. These gaps run for thousands of character ticks. The bench reaches them by stepping through a table of operations. For each one it computes the tick count from the shaped code and checks the gap one tick short of the end and again exactly at the end. It also sends character ticks during each code request, so that any leak of those ticks into the count would shift the end point.

// File: rtl/tape_gap_pkg.sv
package tape_gap_pkg;

  localparam int GAP_CNT_W = 8;
  localparam int GAP_PRE_W = 5;

  typedef enum logic [2:0] {
    PH_READ  = 3'b000,
    PH_DECEL = 3'b011,
    PH_IDLE  = 3'b100,
    PH_ACCEL = 3'b101
  } phase_t;

  localparam logic [GAP_CNT_W-1:0] READ_FLOOR_BITS = 8'h01;
  localparam logic [GAP_CNT_W-1:0] LONG_GAP_BITS   = 8'h60;
  localparam logic [GAP_CNT_W-1:0] BOT_WRITE_BITS  = 8'hC0;
  localparam logic [GAP_CNT_W-1:0] BOT_READ_BITS   = 8'h60;

  typedef struct packed {
    logic write;
    logic filemark;
    logic extgap;
    logic at_bot;
  } op_flags_t;

  // Widen a transport gap code; only the start-up gap is altered.
  function automatic logic [GAP_CNT_W-1:0] shape_code(
    input logic [GAP_CNT_W-1:0] raw,
    input logic                 accel,
    input op_flags_t            f
  );
    logic [GAP_CNT_W-1:0] c;
    c = raw;
    if (accel) begin
      if (!f.write) c = c | READ_FLOOR_BITS;
      if (f.write && (f.filemark || f.extgap)) c = c | LONG_GAP_BITS;
      if (f.at_bot) c = c | (f.write ? BOT_WRITE_BITS : BOT_READ_BITS);
    end
    return c;
  endfunction

endpackage

// File: rtl/gap_code_shaper.sv
module gap_code_shaper
  import tape_gap_pkg::*;
(
  input  logic [GAP_CNT_W-1:0] raw_code,
  input  logic                 accel,
  input  op_flags_t            flags,
  output logic [GAP_CNT_W-1:0] shaped_code
);
  always_comb shaped_code = shape_code(raw_code, accel, flags);
endmodule

// File: rtl/gap_req_timer.sv
module gap_req_timer #(
  parameter int REQ_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int RW = $clog2(REQ_CYCLES + 1);
  localparam logic [RW-1:0] REQ_LEN = RW'(REQ_CYCLES);

  logic [RW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain_q <= '0;
    else if (fire)           remain_q <= REQ_LEN;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/gap_tick_counter.sv
module gap_tick_counter #(
  parameter int PRE_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] code,
  input  logic             run,
  input  logic             tick,
  output logic             step,
  output logic             done
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv  = run && tick && !load;
  assign step = adv && (&pre_q);
  assign done = step && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= '1;
      cnt_q <= ~code;
    end else if (adv) begin
      pre_q <= pre_q + 1'b1;
      if (step) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tape_gap_sequencer.sv
module tape_gap_sequencer
  import tape_gap_pkg::*;
#(
  parameter int REQ_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic       cmd_rewind,
  input  logic       cmd_write,
  input  logic       cmd_filemark,
  input  logic       cmd_extgap,
  input  logic       at_bot,
  input  logic [7:0] delay_code,
  input  logic       char_tick,
  input  logic       eor_strobe,
  output logic       motion_en,
  output logic       read_en,
  output logic       code_req,
  output logic       code_sel_decel,
  output logic       delay_active,
  output logic [2:0] phase
);
  phase_t    phase_q, phase_d;
  logic      motion_q, motion_d;
  logic      sel_q, sel_d;
  op_flags_t flags_q;

  logic start_ok, eor_ok, fire, req_busy, run, gap_done, gap_step;
  logic [GAP_CNT_W-1:0] shaped;

  assign start_ok = op_start && (phase_q == PH_IDLE);
  assign eor_ok   = eor_strobe && (phase_q == PH_READ);
  assign fire     = (start_ok && !cmd_rewind) || eor_ok;
  assign run      = phase_q[0] && !req_busy;

  gap_req_timer #(.REQ_CYCLES(REQ_CYCLES)) u_req (
    .clk(clk), .rst_n(rst_n), .fire(fire), .busy(req_busy)
  );

  gap_code_shaper u_shape (
    .raw_code(delay_code), .accel(phase_q == PH_ACCEL),
    .flags(flags_q), .shaped_code(shaped)
  );

  gap_tick_counter #(.PRE_W(GAP_PRE_W), .CNT_W(GAP_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(req_busy), .code(shaped),
    .run(run), .tick(char_tick), .step(gap_step), .done(gap_done)
  );

  always_comb begin
    phase_d  = phase_q;
    motion_d = motion_q;
    sel_d    = sel_q;
    unique case (phase_q)
      PH_IDLE: begin
        motion_d = start_ok;
        if (start_ok && !cmd_rewind) begin
          phase_d = PH_ACCEL;
          sel_d   = 1'b0;
        end
      end
      PH_ACCEL: if (gap_done) phase_d = PH_READ;
      PH_READ: if (eor_ok) begin
        phase_d = PH_DECEL;
        sel_d   = 1'b1;
      end
      PH_DECEL: if (gap_done) begin
        phase_d  = PH_IDLE;
        motion_d = 1'b0;
      end
      default: begin
        phase_d  = PH_IDLE;
        motion_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      motion_q <= 1'b0;
      sel_q    <= 1'b0;
      flags_q  <= '0;
    end else begin
      phase_q  <= phase_d;
      motion_q <= motion_d;
      sel_q    <= sel_d;
      if (start_ok && !cmd_rewind)
        flags_q <= '{write: cmd_write, filemark: cmd_filemark,
                     extgap: cmd_extgap, at_bot: at_bot};
    end
  end

  assign motion_en      = motion_q;
  assign read_en        = (phase_q == PH_READ);
  assign code_req       = req_busy;
  assign code_sel_decel = sel_q;
  assign delay_active   = phase_q[0];
  assign phase          = phase_q;
endmodule

// File: rtl/gap_seq_checker.sv
module gap_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       motion_en,
  input logic       read_en,
  input logic       code_req,
  input logic       code_sel_decel,
  input logic       delay_active,
  input logic [2:0] phase,
  input logic       gap_step
);
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b100) || (phase == 3'b101) || (phase == 3'b000) || (phase == 3'b011)); // R1
  AST_REQ_IN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    code_req |-> delay_active); // R2
  AST_REQ_OPENS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_req) |-> $rose(delay_active)); // R8
  AST_NO_STEP_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    code_req |-> !gap_step); // R3
  AST_READ_AFTER_ACCEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_en) |-> $fell(delay_active)); // R7
  AST_STOP_AFTER_DECEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(delay_active) && code_sel_decel) |-> !motion_en); // R9
  AST_MOTION_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'b100) |-> motion_en); // R2
endmodule

bind tape_gap_sequencer gap_seq_checker u_gap_chk (
  .clk(clk), .rst_n(rst_n), .motion_en(motion_en), .read_en(read_en),
  .code_req(code_req), .code_sel_decel(code_sel_decel),
  .delay_active(delay_active), .phase(phase), .gap_step(gap_step)
);

// File: tb/test_tape_gap_sequencer.sv
module test_tape_gap_sequencer;
  localparam int REQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, cmd_rewind = 0, cmd_write = 0, cmd_filemark = 0, cmd_extgap = 0, at_bot = 0;
  logic [7:0] delay_code = '0;
  logic char_tick = 0, eor_strobe = 0;
  logic motion_en, read_en, code_req, code_sel_decel, delay_active;
  logic [2:0] phase;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tape_gap_sequencer #(.REQ_CYCLES(REQ)) i_tape_gap_sequencer (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .cmd_rewind(cmd_rewind),
    .cmd_write(cmd_write), .cmd_filemark(cmd_filemark), .cmd_extgap(cmd_extgap),
    .at_bot(at_bot), .delay_code(delay_code), .char_tick(char_tick),
    .eor_strobe(eor_strobe), .motion_en(motion_en), .read_en(read_en),
    .code_req(code_req), .code_sel_decel(code_sel_decel),
    .delay_active(delay_active), .phase(phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Gap length from the requirement arithmetic: bit groups as sums of powers of two.
  function automatic int expect_code(input int raw, input bit wr, input bit fm,
                                     input bit ext, input bit bot);
    int bits[8];
    int v;
    for (int i = 0; i < 8; i++) bits[i] = (raw >> i) & 1;
    if (!wr) bits[0] = 1;                                  // R4
    if (wr && (fm || ext)) begin bits[5] = 1; bits[6] = 1; end // R5
    if (bot && wr) begin bits[6] = 1; bits[7] = 1; end     // R6
    if (bot && !wr) begin bits[5] = 1; bits[6] = 1; end    // R6
    v = 0;
    for (int i = 0; i < 8; i++) v += bits[i] * (2 ** i);
    return v;
  endfunction

  task automatic pulse_tick();
    @(negedge clk) char_tick = 1;
    @(negedge clk) char_tick = 0;
  endtask

  // Wait out a code request, feeding ticks into it that must be ignored (R3).
  task automatic ride_request(input string req, input bit want_sel);
    int len = 0;
    check(code_req === 1'b1, req, code_req, 1);
    check(code_sel_decel === want_sel, req, code_sel_decel, want_sel);
    while (code_req === 1'b1 && len < 100) begin
      char_tick = 1;
      @(negedge clk);
      len++;
    end
    char_tick = 0;
    check(len == REQ, "R2 request length", len, REQ);
  endtask

  task automatic run_gap(input int c, input string req, input logic [2:0] after_ph);
    int n = 1 + 32 * c;
    for (int i = 0; i < n - 1; i++) pulse_tick();
    check(delay_active === 1'b1, {"R3 one tick short ", req}, delay_active, 1);
    pulse_tick();
    check(delay_active === 1'b0, {"R3 at end ", req}, delay_active, 0);
    check(phase === after_ph, req, phase, after_ph);
  endtask

  task automatic run_op(input bit wr, input bit fm, input bit ext, input bit bot,
                        input int acode, input int dcode, input string req);
    int c;
    @(negedge clk);
    cmd_rewind = 0; cmd_write = wr; cmd_filemark = fm; cmd_extgap = ext; at_bot = bot;
    delay_code = 8'(acode);
    op_start = 1;
    @(negedge clk) op_start = 0;
    check(phase === 3'b101, "R2 start-up phase", phase, 3'b101);
    check(motion_en === 1'b1, "R2 motion on", motion_en, 1);
    ride_request("R2 start-up request", 1'b0);
    // R11: a second start and a stray end-of-record during the gap
    op_start = 1; eor_strobe = 1;
    @(negedge clk) begin op_start = 0; eor_strobe = 0; end
    check(phase === 3'b101 && !code_req, "R11 ignored in gap", phase, 3'b101);
    c = expect_code(acode, wr, fm, ext, bot);
    run_gap(c, req, 3'b000);
    check(read_en === 1'b1, "R7 reading", read_en, 1);
    repeat (3) @(negedge clk);
    check(phase === 3'b000 && motion_en, "R7 holds reading", phase, 3'b000);
    delay_code = 8'(dcode);
    eor_strobe = 1;
    @(negedge clk) eor_strobe = 0;
    check(phase === 3'b011, "R8 slow-down phase", phase, 3'b011);
    ride_request("R8 slow-down request", 1'b1);
    run_gap(dcode, "R8 slow-down code unchanged", 3'b100);
    check(motion_en === 1'b0 && read_en === 1'b0, "R9 stopped", motion_en, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phase === 3'b100, "R1 reset phase", phase, 3'b100);
    check(!motion_en && !read_en && !code_req && !delay_active, "R1 reset outputs",
          motion_en, 0);
    rst_n = 1;
    @(negedge clk);
    // R11: end-of-record while waiting does nothing
    eor_strobe = 1;
    @(negedge clk) eor_strobe = 0;
    check(phase === 3'b100 && !code_req && !motion_en, "R11 eor while waiting", phase, 3'b100);
    // R10 rewind
    cmd_rewind = 1; op_start = 1;
    @(negedge clk) begin op_start = 0; end
    check(motion_en === 1'b1 && phase === 3'b100 && !code_req, "R10 rewind pulse", motion_en, 1);
    @(negedge clk);
    check(motion_en === 1'b0 && phase === 3'b100 && !code_req, "R10 rewind done", motion_en, 0);
    cmd_rewind = 0;
    run_op(0, 0, 0, 0, 0,    0, "R4 read code 0");
    run_op(0, 0, 0, 0, 6,    3, "R4 read code 6");
    run_op(0, 0, 0, 0, 5,    1, "R4 read code 5");
    run_op(1, 0, 0, 0, 0,    2, "R5 plain write 0");
    run_op(1, 1, 0, 0, 4,    0, "R5 filemark write");
    run_op(1, 0, 1, 0, 8'h20, 0, "R5 long gap merge");
    run_op(0, 1, 1, 0, 2,    0, "R5 flags ignored on read");
    run_op(1, 0, 0, 1, 2,    0, "R6 write at bot");
    run_op(1, 1, 0, 1, 1,    0, "R6 write bot filemark merge");
    run_op(0, 0, 0, 1, 0,    0, "R6 read at bot");
    report();
  end
endmodule